// File: doc/BRIEF.md
# Shadowed SRAM Host Timing Sequencer

This block sits between a simple command port and a small nonvolatile-backed static RAM (64 words of 4 bits, with a bit-for-bit shadow copy that can be saved or reloaded as a whole). A requester offers one of four operations (read a word, write a word, save the whole RAM into the shadow, reload the whole RAM from the shadow) with a valid/ready handshake. The sequencer then drives the active-low memory strobes, the address and the data lines with the setup, pulse, recovery and completion intervals each operation needs, and reports completion with a one-cycle done pulse.

Every interval is given as a parameter in nanoseconds and converted to clock cycles from a clock-period parameter, so the same block serves any clock rate. One operation runs at a time; while it runs, the port is not ready and nothing is queued. The data lines are split into an output word, an output enable and an input word, so the tri-state pad sits outside the block.

States: `ST_IDLE` (ready, strobes inactive), `ST_WR_SETUP` (chip select low, address stable, write enable high), `ST_WR_PULSE` (write enable low, data driven), `ST_WR_RECOVER` (strobes high, address held), `ST_RD_ACCESS` (chip select low, write enable high, data sampled in the last cycle), `ST_SV_PULSE` (save strobe low), `ST_SV_WAIT` (save completion wait), `ST_RC_PULSE` (reload strobe low), `ST_RC_WAIT` (reload completion wait). Transitions: an accepted request leaves `ST_IDLE` for `ST_RD_ACCESS`, `ST_WR_SETUP`, `ST_SV_PULSE` or `ST_RC_PULSE` by opcode; each timed state moves to its successor when its interval expires (setup to pulse to recover to idle; access to idle; save pulse to save wait to idle; reload pulse to reload wait to idle).

Top module: `nvsram_host_seq`

## Requirements
- R1: After reset, cmd_ready is 1, busy is 0, done is 0, mem_dq_oe is 0 and all four strobes (mem_cs_n, mem_we_n, mem_store_n, mem_recall_n) are 1.
- R2: A request is taken only on a clock edge where cmd_valid and cmd_ready are both 1; cmd_ready is 0 (busy 1) from the next cycle until the whole operation including its final wait has ended, and requests offered while cmd_ready is 0 are ignored. Opcodes on cmd_op: 2'b00 read, 2'b01 write, 2'b10 save, 2'b11 reload.
- R3: A write holds mem_cs_n low with mem_we_n high for ceil(T_AS) cycles, then mem_we_n low for max(ceil(T_WP), ceil(T_DW)) cycles, then both strobes high for max(ceil(T_WR), ceil(T_WC) minus the first two intervals) cycles, with mem_addr equal to the requested address throughout.
- R4: mem_dq_oe is 1 exactly in the cycles where mem_we_n is low, and mem_dq_out then carries the requested write word, so the addressed word takes that value.
- R5: A read holds mem_cs_n low and mem_we_n high for max(ceil(T_AA), ceil(T_RC)) cycles; rd_data then shows mem_dq_in as sampled in the last of those cycles.
- R6: mem_store_n and mem_recall_n stay 1 throughout reads and writes.
- R7: A save holds mem_store_n low for ceil(T_STP) cycles, then waits ceil(T_STC) cycles with all strobes high before cmd_ready returns.
- R8: A reload holds mem_recall_n low for ceil(T_RCP) cycles, then waits max(ceil(T_ARC), ceil(T_RCC) minus the pulse) cycles before cmd_ready returns.
- R9: done is 1 for exactly one cycle, the first cycle in which cmd_ready is 1 again after any operation; rd_data changes only at the end of a read.
- R10: Each nanosecond interval becomes ceil(ns / CLK_NS) cycles, and at least one cycle.
- R11: mem_store_n is never low while mem_we_n is low, and mem_store_n and mem_recall_n are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Request offered |
| cmd_ready | output | 1 | Sequencer idle, request can be taken |
| cmd_op | input | 2 | Opcode: 00 read, 01 write, 10 save, 11 reload |
| cmd_addr | input | ADDR_W | Word address of a read or write |
| cmd_wdata | input | DATA_W | Word to write |
| rd_data | output | DATA_W | Word returned by the last read |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | An operation is in progress |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_store_n | output | 1 | Save-to-shadow strobe, active low |
| mem_recall_n | output | 1 | Reload-from-shadow strobe, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the data driver |
| mem_dq_in | input | DATA_W | Data returned by the memory |

## Verification
The completion of one operation and the acceptance of the next can fall in the same cycle: done rises in the first idle cycle, and a request held valid is taken at the edge that ends that cycle. The bench provokes this by keeping cmd_valid high from a write straight into a read of the same word, and judges it by the done pulse being seen in that cycle, the read timing being intact and the read returning the freshly written word. It also keeps a different request valid during a whole save, and judges at the pins that no write strobe appears and the target word is unchanged.

// File: rtl/nvsram_seq_pkg.sv
package nvsram_seq_pkg;

    typedef enum logic [1:0] {
        CMD_READ   = 2'b00,
        CMD_WRITE  = 2'b01,
        CMD_STORE  = 2'b10,
        CMD_RECALL = 2'b11
    } cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOVER,
        ST_RD_ACCESS,
        ST_SV_PULSE,
        ST_SV_WAIT,
        ST_RC_PULSE,
        ST_RC_WAIT
    } seq_state_e;

    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic store_n;
        logic recall_n;
        logic dq_oe;
    } pin_set_t;

    // Round a nanosecond interval up to whole clock cycles, never below one.
    function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        if (c == 0) c = 1;
        return c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // a - b, clamped at zero
    function automatic int unsigned sub_sat(input int unsigned a, input int unsigned b);
        return (a > b) ? (a - b) : 0;
    endfunction

endpackage

// File: rtl/nvs_interval_timer.sv
module nvs_interval_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // A load of N makes the following state last N cycles.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/nvs_pin_driver.sv
module nvs_pin_driver
    import nvsram_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_e next_state,
    output pin_set_t   pins
);

    pin_set_t pins_d;

    // Pin pattern of the state about to be entered; registered so the pins are glitch free.
    always_comb begin
        pins_d = '{cs_n: 1'b1, we_n: 1'b1, store_n: 1'b1, recall_n: 1'b1, dq_oe: 1'b0};
        unique case (next_state)
            ST_IDLE:       ;
            ST_WR_SETUP:   pins_d.cs_n = 1'b0;
            ST_WR_PULSE: begin
                pins_d.cs_n  = 1'b0;
                pins_d.we_n  = 1'b0;
                pins_d.dq_oe = 1'b1;
            end
            ST_WR_RECOVER: ;
            ST_RD_ACCESS:  pins_d.cs_n = 1'b0;
            ST_SV_PULSE:   pins_d.store_n = 1'b0;
            ST_SV_WAIT:    ;
            ST_RC_PULSE:   pins_d.recall_n = 1'b0;
            ST_RC_WAIT:    ;
            default:       ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pins <= '{cs_n: 1'b1, we_n: 1'b1, store_n: 1'b1, recall_n: 1'b1, dq_oe: 1'b0};
        end else begin
            pins <= pins_d;
        end
    end

endmodule

// File: rtl/nvs_read_capture.sv
module nvs_read_capture #(
    parameter int unsigned DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rd_data
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (sample) begin
            rd_data <= dq_in;
        end
    end

endmodule

// File: rtl/nvsram_host_seq.sv
module nvsram_host_seq
    import nvsram_seq_pkg::*;
#(
    parameter int unsigned CLK_NS   = 20,
    parameter int unsigned ADDR_W   = 6,
    parameter int unsigned DATA_W   = 4,
    parameter int unsigned T_AS_NS  = 50,
    parameter int unsigned T_WP_NS  = 150,
    parameter int unsigned T_WR_NS  = 25,
    parameter int unsigned T_WC_NS  = 200,
    parameter int unsigned T_DW_NS  = 100,
    parameter int unsigned T_AA_NS  = 200,
    parameter int unsigned T_RC_NS  = 200,
    parameter int unsigned T_STP_NS = 200,
    parameter int unsigned T_STC_NS = 10_000_000,
    parameter int unsigned T_RCP_NS = 300,
    parameter int unsigned T_RCC_NS = 1400,
    parameter int unsigned T_ARC_NS = 1100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              busy,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_store_n,
    output logic              mem_recall_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    // Interval lengths in cycles
    localparam int unsigned C_AS   = ns_to_cycles(T_AS_NS, CLK_NS);
    localparam int unsigned C_WPL  = max2(ns_to_cycles(T_WP_NS, CLK_NS), ns_to_cycles(T_DW_NS, CLK_NS));
    localparam int unsigned C_WREC = max2(ns_to_cycles(T_WR_NS, CLK_NS),
                                          sub_sat(ns_to_cycles(T_WC_NS, CLK_NS), C_AS + C_WPL));
    localparam int unsigned C_RD   = max2(ns_to_cycles(T_AA_NS, CLK_NS), ns_to_cycles(T_RC_NS, CLK_NS));
    localparam int unsigned C_STP  = ns_to_cycles(T_STP_NS, CLK_NS);
    localparam int unsigned C_STC  = ns_to_cycles(T_STC_NS, CLK_NS);
    localparam int unsigned C_RCP  = ns_to_cycles(T_RCP_NS, CLK_NS);
    localparam int unsigned C_RCW  = max2(ns_to_cycles(T_ARC_NS, CLK_NS),
                                          sub_sat(ns_to_cycles(T_RCC_NS, CLK_NS), C_RCP));
    localparam int unsigned C_MAX  = max2(max2(max2(C_AS, C_WPL), max2(C_WREC, C_RD)),
                                          max2(max2(C_STP, C_STC), max2(C_RCP, C_RCW)));
    localparam int unsigned CNT_W  = $clog2(C_MAX + 1);

    seq_state_e        state_q, state_d;
    logic              timer_load, timer_done;
    logic [CNT_W-1:0]  timer_val;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              done_q;
    logic              accept;
    pin_set_t          pins;

    assign cmd_ready = (state_q == ST_IDLE);
    assign busy      = ~cmd_ready;
    assign accept    = cmd_valid & cmd_ready;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    unique case (cmd_e'(cmd_op))
                        CMD_READ:   state_d = ST_RD_ACCESS;
                        CMD_WRITE:  state_d = ST_WR_SETUP;
                        CMD_STORE:  state_d = ST_SV_PULSE;
                        CMD_RECALL: state_d = ST_RC_PULSE;
                        default:    state_d = ST_IDLE;
                    endcase
                end
            end
            ST_WR_SETUP:   if (timer_done) state_d = ST_WR_PULSE;
            ST_WR_PULSE:   if (timer_done) state_d = ST_WR_RECOVER;
            ST_WR_RECOVER: if (timer_done) state_d = ST_IDLE;
            ST_RD_ACCESS:  if (timer_done) state_d = ST_IDLE;
            ST_SV_PULSE:   if (timer_done) state_d = ST_SV_WAIT;
            ST_SV_WAIT:    if (timer_done) state_d = ST_IDLE;
            ST_RC_PULSE:   if (timer_done) state_d = ST_RC_WAIT;
            ST_RC_WAIT:    if (timer_done) state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // Interval loaded on entry to each timed state
    always_comb begin
        timer_load = (state_d != state_q);
        unique case (state_d)
            ST_WR_SETUP:   timer_val = CNT_W'(C_AS);
            ST_WR_PULSE:   timer_val = CNT_W'(C_WPL);
            ST_WR_RECOVER: timer_val = CNT_W'(C_WREC);
            ST_RD_ACCESS:  timer_val = CNT_W'(C_RD);
            ST_SV_PULSE:   timer_val = CNT_W'(C_STP);
            ST_SV_WAIT:    timer_val = CNT_W'(C_STC);
            ST_RC_PULSE:   timer_val = CNT_W'(C_RCP);
            ST_RC_WAIT:    timer_val = CNT_W'(C_RCW);
            default:       timer_val = CNT_W'(1);
        endcase
    end

    nvs_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_val),
        .expired  (timer_done)
    );

    // Request operands held for the whole operation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= cmd_addr;
            wdata_q <= cmd_wdata;
        end
    end

    // Completion pulse: first idle cycle after an operation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= (state_q != ST_IDLE) && (state_d == ST_IDLE);
        end
    end

    nvs_pin_driver u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .next_state (state_d),
        .pins       (pins)
    );

    nvs_read_capture #(.DATA_W(DATA_W)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .sample  ((state_q == ST_RD_ACCESS) && timer_done),
        .dq_in   (mem_dq_in),
        .rd_data (rd_data)
    );

    assign done         = done_q;
    assign mem_cs_n     = pins.cs_n;
    assign mem_we_n     = pins.we_n;
    assign mem_store_n  = pins.store_n;
    assign mem_recall_n = pins.recall_n;
    assign mem_dq_oe    = pins.dq_oe;
    assign mem_addr     = addr_q;
    assign mem_dq_out   = wdata_q;

endmodule

// File: rtl/nvsram_host_seq_chk.sv
module nvsram_host_seq_chk #(
    parameter int unsigned ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              done,
    input logic              mem_cs_n,
    input logic              mem_we_n,
    input logic              mem_store_n,
    input logic              mem_recall_n,
    input logic              mem_dq_oe,
    input logic [ADDR_W-1:0] mem_addr
);

    assert_dq_in_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && !mem_cs_n));

    assert_no_save_in_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_store_n && !mem_we_n));

    assert_strobes_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_store_n && !mem_recall_n));

    assert_busy_while_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n || !mem_store_n || !mem_recall_n) |-> !cmd_ready);

    assert_accept_drops_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_when_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cmd_ready);

    assert_addr_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));

    assert_side_strobes_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |-> (mem_store_n && mem_recall_n));

endmodule

bind nvsram_host_seq nvsram_host_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .done         (done),
    .mem_cs_n     (mem_cs_n),
    .mem_we_n     (mem_we_n),
    .mem_store_n  (mem_store_n),
    .mem_recall_n (mem_recall_n),
    .mem_dq_oe    (mem_dq_oe),
    .mem_addr     (mem_addr)
);

// File: tb/nvsram_host_seq_test.sv
module nvsram_host_seq_test;

    localparam int CLK = 20;
    localparam int STC_NS = 2000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic [1:0] cmd_op = 2'b00;
    logic [5:0] cmd_addr = '0;
    logic [3:0] cmd_wdata = '0;
    logic [3:0] rd_data;
    logic       done, busy;
    logic       mem_cs_n, mem_we_n, mem_store_n, mem_recall_n, mem_dq_oe;
    logic [5:0] mem_addr;
    logic [3:0] mem_dq_out, mem_dq_in;

    int errors = 0;
    int checks = 0;
    int cyc_count = 0;

    always #(CLK/2) clk = ~clk;

    nvsram_host_seq #(.CLK_NS(CLK), .T_STC_NS(STC_NS)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rd_data(rd_data),
        .done(done), .busy(busy), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_store_n(mem_store_n), .mem_recall_n(mem_recall_n), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // Behavioural memory with shadow copy
    logic [3:0] ram [64];
    logic [3:0] shadow [64];
    logic prev_st = 1'b1, prev_rc = 1'b1;

    assign mem_dq_in = (!mem_cs_n && mem_we_n) ? ram[mem_addr] : 4'h0;

    always @(negedge clk) begin
        if (!mem_cs_n && !mem_we_n && mem_dq_oe) ram[mem_addr] = mem_dq_out;
        if (!prev_st && mem_store_n) for (int i = 0; i < 64; i++) shadow[i] = ram[i];
        if (!prev_rc && mem_recall_n) for (int i = 0; i < 64; i++) ram[i] = shadow[i];
        prev_st = mem_store_n;
        prev_rc = mem_recall_n;
    end

    function automatic int cyc(input int ns);
        int c;
        c = (ns + CLK - 1) / CLK;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Expected intervals (R10)
    int e_as, e_wpl, e_wrec, e_rd, e_stp, e_stc, e_rcp, e_rcw;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Trace measurements of the last operation
    int n_busy, n_setup, n_welow, n_oe, n_oe_bad, n_cslow, n_stlow, n_rclow;
    int n_side_bad, n_addr_bad, n_post_strobe, n_done_early;
    bit done_seen;
    bit hung = 1'b0;

    // Issue a request at a negedge; trace until ready returns.
    // keep_valid: leave valid asserted at return; alien: offer a write to alien_addr while busy.
    task automatic run_cmd(input logic [1:0] op, input logic [5:0] a, input logic [3:0] d,
                           input bit keep_valid, input bit alien, input logic [5:0] alien_addr);
        bit we_seen;
        bit rec_phase;
        cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_valid = 1'b1;
        @(posedge clk);
        n_busy = 0; n_setup = 0; n_welow = 0; n_oe = 0; n_oe_bad = 0; n_cslow = 0;
        n_stlow = 0; n_rclow = 0; n_side_bad = 0; n_addr_bad = 0; n_post_strobe = 0;
        n_done_early = 0; we_seen = 1'b0; rec_phase = 1'b0;
        forever begin
            @(negedge clk);
            if (alien) begin
                cmd_op = 2'b01; cmd_addr = alien_addr; cmd_wdata = 4'hF; cmd_valid = 1'b1;
            end else begin
                cmd_valid = 1'b0;
            end
            if (cmd_ready) break;
            n_busy++;
            if (done) n_done_early++;
            if (!mem_cs_n) n_cslow++;
            if (!mem_cs_n && mem_we_n && !we_seen) n_setup++;
            if (!mem_we_n) begin n_welow++; we_seen = 1'b1; end
            if (we_seen && mem_we_n) rec_phase = 1'b1;
            if (rec_phase && (!mem_cs_n || !mem_we_n)) n_post_strobe++;
            if (mem_dq_oe) begin
                n_oe++;
                if (mem_we_n || mem_dq_out != d) n_oe_bad++;
            end
            if (!mem_store_n) n_stlow++;
            if (!mem_recall_n) n_rclow++;
            if ((op == 2'b00 || op == 2'b01) && (!mem_store_n || !mem_recall_n)) n_side_bad++;
            if ((op == 2'b00 || op == 2'b01) && mem_addr != a) n_addr_bad++;
            if (n_busy > 4000) begin hung = 1'b1; break; end
        end
        done_seen = done;
        if (keep_valid) cmd_valid = 1'b1;
        else cmd_valid = 1'b0;
        if (!keep_valid && !hung) begin
            @(negedge clk);
            check(!done, "R9 done single cycle", int'(done), 0);
        end
    endtask

    task automatic do_write(input logic [5:0] a, input logic [3:0] d);
        run_cmd(2'b01, a, d, 1'b0, 1'b0, 6'd0);
        check(n_setup == e_as, "R3 write setup", n_setup, e_as);
        check(n_welow == e_wpl, "R3 write pulse", n_welow, e_wpl);
        check(n_busy == e_as + e_wpl + e_wrec, "R3 write cycle length", n_busy, e_as + e_wpl + e_wrec);
        check(n_post_strobe == 0, "R3 recovery strobes high", n_post_strobe, 0);
        check(n_addr_bad == 0, "R3 address held", n_addr_bad, 0);
        check(n_oe == n_welow && n_oe_bad == 0, "R4 data drive window", n_oe, n_welow);
        check(n_side_bad == 0, "R6 side strobes in write", n_side_bad, 0);
        check(done_seen, "R9 done after write", int'(done_seen), 1);
        check(n_done_early == 0, "R9 no done while busy", n_done_early, 0);
    endtask

    task automatic do_read(input logic [5:0] a, input logic [3:0] exp);
        run_cmd(2'b00, a, 4'h0, 1'b0, 1'b0, 6'd0);
        check(n_cslow == e_rd && n_welow == 0, "R5 read access length", n_cslow, e_rd);
        check(n_busy == e_rd, "R2 read busy length", n_busy, e_rd);
        check(rd_data == exp, "R5 read data", int'(rd_data), int'(exp));
        check(n_side_bad == 0 && n_addr_bad == 0, "R6 side strobes in read", n_side_bad, 0);
        check(n_oe == 0, "R4 no drive in read", n_oe, 0);
    endtask

    function automatic logic [3:0] pat(input int i);
        return 4'((i * 7 + 3) ^ (i >> 3));
    endfunction

    initial begin
        e_as = cyc(50);
        e_wpl = mx(cyc(150), cyc(100));
        e_wrec = mx(cyc(25), cyc(200) - e_as - e_wpl);
        e_rd = mx(cyc(200), cyc(200));
        e_stp = cyc(200);
        e_stc = cyc(STC_NS);
        e_rcp = cyc(300);
        e_rcw = mx(cyc(1100), cyc(1400) - e_rcp);
        for (int i = 0; i < 64; i++) begin ram[i] = 4'h0; shadow[i] = 4'h0; end

        repeat (3) @(negedge clk);
        // R1 reset state
        check(cmd_ready && !busy && !done, "R1 reset handshake", int'(cmd_ready), 1);
        check(mem_cs_n && mem_we_n && mem_store_n && mem_recall_n && !mem_dq_oe,
              "R1 reset pins", int'({mem_cs_n, mem_we_n, mem_store_n, mem_recall_n, mem_dq_oe}), 30);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_ready && mem_cs_n, "R1 idle after reset", int'(cmd_ready), 1);

        // Exhaustive write and readback (R3 R4 R5 R10)
        for (int i = 0; i < 64; i++) do_write(6'(i), pat(i));
        for (int i = 0; i < 64; i++) do_read(6'(i), pat(i));

        // R9: rd_data untouched by a write
        begin
            logic [3:0] held;
            held = rd_data;
            do_write(6'd5, pat(5));
            check(rd_data == held, "R9 rd_data kept over write", int'(rd_data), int'(held));
        end

        // Save (R7), with a foreign write request held valid while busy (R2)
        run_cmd(2'b10, 6'd0, 4'h0, 1'b0, 1'b1, 6'd9);
        check(n_stlow == e_stp, "R7 save pulse", n_stlow, e_stp);
        check(n_busy == e_stp + e_stc, "R7 save completion wait", n_busy, e_stp + e_stc);
        check(n_welow == 0 && n_cslow == 0 && n_rclow == 0, "R2 request ignored while busy", n_welow, 0);
        check(n_oe == 0, "R4 no drive in save", n_oe, 0);
        check(done_seen, "R9 done after save", int'(done_seen), 1);
        check(ram[9] == pat(9), "R2 ignored write left word", int'(ram[9]), int'(pat(9)));

        // Overwrite with complement, verify
        for (int i = 0; i < 64; i++) do_write(6'(i), ~pat(i));
        for (int i = 0; i < 64; i += 5) do_read(6'(i), ~pat(i));

        // Reload (R8) restores the saved image
        run_cmd(2'b11, 6'd0, 4'h0, 1'b0, 1'b0, 6'd0);
        check(n_rclow == e_rcp, "R8 reload pulse", n_rclow, e_rcp);
        check(n_busy == e_rcp + e_rcw, "R8 reload completion wait", n_busy, e_rcp + e_rcw);
        check(n_stlow == 0 && n_cslow == 0, "R11 strobes exclusive in reload", n_stlow, 0);
        check(done_seen, "R9 done after reload", int'(done_seen), 1);
        for (int i = 0; i < 64; i++) do_read(6'(i), pat(i));

        // Back to back: write completes and read is taken in the done cycle (R2 R9)
        run_cmd(2'b01, 6'd33, 4'hA, 1'b1, 1'b0, 6'd0);
        check(done_seen, "R9 done in handover cycle", int'(done_seen), 1);
        check(n_welow == e_wpl, "R3 pulse before handover", n_welow, e_wpl);
        do_read(6'd33, 4'hA);

        if (hung) check(1'b0, "R2 operation never completed", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        cyc_count++;
        if (cyc_count > 150000) begin
            errors++;
            checks++;
            $display("FAIL R2 watchdog expired: actual=%0d expected=%0d", cyc_count, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule